// File: doc/BRIEF.md
# Quadratic Polynomial Evaluator

This block evaluates C·x² + B·x + A on 8-bit unsigned operands. A short controller drives a small datapath. The datapath has four operand registers, one result register, two 4-to-1 operand selectors and a single arithmetic unit that either adds or multiplies. Operands enter one word at a time on a valid/ready input stream, in the fixed order A, B, C, x.

Once the fourth word is accepted, the controller runs five fixed compute steps. It reuses the one arithmetic unit in each step and writes partial results back into the A and B registers as scratch space. The last step writes the answer into the result register. A one-cycle done pulse marks the moment the result becomes visible. The result then stays unchanged and no further input is accepted until the next reset. The operands are assumed small enough that no partial or final value exceeds 255. Wider results wrap modulo 256.

Input stream rules: a word transfers on a rising clock edge when `in_valid` and `in_ready` are both high. The source may hold `in_valid` low for any number of cycles between words; this is back-pressure from the source side. The block raises `in_ready` only while it still expects operands. `in_data` is ignored in every cycle where no transfer takes place.

Top module: `quad_eval`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), `result` is 0, `done` is 0 and `in_ready` is 1.
- R2: After reset, the first four accepted words are taken as A, B, C and x, in that order.
- R3: `in_ready` is 1 until the fourth word is accepted and 0 after that until the next reset. Words offered while `in_ready` is 0 are not transferred.
- R4: For operands whose partial products and sums all stay within 255, `result` equals C·x² + B·x + A.
- R5: `done` goes high exactly 5 clock cycles after the edge that accepts x. It stays high for exactly one cycle, and `result` holds the final value in that same cycle.
- R6: After the done pulse, `result` stays constant and `done` stays 0 until the next reset, whatever is applied at the input.
- R7: Asserting `rst_n` low in the middle of loading or computing clears the outputs immediately. After release, loading restarts with A.
- R8: In cycles where `in_valid` is 0, `in_data` has no effect on any register, so stalls of any length between words leave the result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand word present on `in_data` |
| in_ready | output | 1 | Block still accepts operand words |
| in_data | input | 8 | Operand word (A, B, C, x in order) |
| result | output | 8 | Evaluated polynomial value |
| done | output | 1 | One-cycle pulse when `result` becomes final |

## Verification
A controller state that is off by one step shows up as a done pulse one cycle early or late, so the timing check catches it on the first evaluation. A wrong selector code or a wrong scratch write-back corrupts the value captured five cycles after x is accepted, and a reference comparison over several operand sets exposes it. A load-order error or a leak of stalled input data changes the final value in the same way. A controller that fails to park after the result shows up within a few cycles, as a second done pulse, a changing result or a raised `in_ready`.

// File: rtl/qe_pkg.sv
package qe_pkg;
  localparam int N_OPD     = 4;  // operand registers: A, B, C, x
  localparam int N_SCRATCH = 2;  // A and B may take ALU results

  typedef enum logic [3:0] {
    ST_LD_A, ST_LD_B, ST_LD_C, ST_LD_X,
    ST_MUL_BX, ST_ADD_AB, ST_MUL_CX, ST_MUL_BX2,
    ST_FIN, ST_HOLD
  } qe_state_e;

  typedef enum logic [1:0] {
    SRC_A = 2'd0,
    SRC_B = 2'd1,
    SRC_C = 2'd2,
    SRC_X = 2'd3
  } qe_src_e;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_MUL = 1'b1
  } qe_op_e;

  typedef struct packed {
    logic    ld_a;
    logic    ld_b;
    logic    ld_c;
    logic    ld_x;
    logic    ld_r;
    logic    use_alu;
    qe_src_e sel_p;
    qe_src_e sel_q;
    qe_op_e  op;
  } qe_ctl_t;
endpackage

// File: rtl/qe_reg.sv
module qe_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/qe_opmux.sv
module qe_opmux #(
  parameter int W = 8,
  parameter int N = 4,
  localparam int SW = $clog2(N)
) (
  input  logic [N*W-1:0] srcs,
  input  logic [SW-1:0]  sel,
  output logic [W-1:0]   y
);
  always_comb y = srcs[sel*W +: W];
endmodule

// File: rtl/qe_alu.sv
module qe_alu import qe_pkg::*; #(
  parameter int W = 8
) (
  input  qe_op_e       op,
  input  logic [W-1:0] p,
  input  logic [W-1:0] q,
  output logic [W-1:0] y
);
  logic [W-1:0] sum;
  logic [W-1:0] prod;

  always_comb begin
    sum  = p + q;
    prod = p * q;
    y    = (op == OP_MUL) ? prod : sum;
  end
endmodule

// File: rtl/qe_ctrl.sv
module qe_ctrl import qe_pkg::*; (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    in_valid,
  output logic    in_ready,
  output qe_ctl_t ctl,
  output logic    done
);
  qe_state_e state_q, state_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_LD_A;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      done    <= (state_q == ST_FIN);
    end
  end

  always_comb begin
    state_d   = state_q;
    in_ready  = 1'b0;
    ctl       = '0;
    ctl.sel_p = SRC_A;
    ctl.sel_q = SRC_B;
    ctl.op    = OP_ADD;
    unique case (state_q)
      ST_LD_A: begin
        in_ready = 1'b1;
        ctl.ld_a = in_valid;
        if (in_valid) state_d = ST_LD_B;
      end
      ST_LD_B: begin
        in_ready = 1'b1;
        ctl.ld_b = in_valid;
        if (in_valid) state_d = ST_LD_C;
      end
      ST_LD_C: begin
        in_ready = 1'b1;
        ctl.ld_c = in_valid;
        if (in_valid) state_d = ST_LD_X;
      end
      ST_LD_X: begin
        in_ready = 1'b1;
        ctl.ld_x = in_valid;
        if (in_valid) state_d = ST_MUL_BX;
      end
      ST_MUL_BX: begin           // B <- B*x
        ctl.sel_p   = SRC_B;
        ctl.sel_q   = SRC_X;
        ctl.op      = OP_MUL;
        ctl.use_alu = 1'b1;
        ctl.ld_b    = 1'b1;
        state_d     = ST_ADD_AB;
      end
      ST_ADD_AB: begin           // A <- A + B*x
        ctl.sel_p   = SRC_A;
        ctl.sel_q   = SRC_B;
        ctl.op      = OP_ADD;
        ctl.use_alu = 1'b1;
        ctl.ld_a    = 1'b1;
        state_d     = ST_MUL_CX;
      end
      ST_MUL_CX: begin           // B <- C*x
        ctl.sel_p   = SRC_C;
        ctl.sel_q   = SRC_X;
        ctl.op      = OP_MUL;
        ctl.use_alu = 1'b1;
        ctl.ld_b    = 1'b1;
        state_d     = ST_MUL_BX2;
      end
      ST_MUL_BX2: begin          // B <- C*x*x
        ctl.sel_p   = SRC_B;
        ctl.sel_q   = SRC_X;
        ctl.op      = OP_MUL;
        ctl.use_alu = 1'b1;
        ctl.ld_b    = 1'b1;
        state_d     = ST_FIN;
      end
      ST_FIN: begin              // R <- A + B
        ctl.sel_p   = SRC_A;
        ctl.sel_q   = SRC_B;
        ctl.op      = OP_ADD;
        ctl.ld_r    = 1'b1;
        state_d     = ST_HOLD;
      end
      ST_HOLD: state_d = ST_HOLD;
      default: state_d = ST_LD_A;
    endcase
  end
endmodule

// File: rtl/qe_dpath.sv
module qe_dpath import qe_pkg::*; #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  qe_ctl_t      ctl,
  input  logic [W-1:0] in_data,
  output logic [W-1:0] result
);
  logic [W-1:0]       opd_q [N_OPD];
  logic [N_OPD-1:0]   opd_ld;
  logic [N_OPD*W-1:0] opd_flat;
  logic [W-1:0]       mux_p, mux_q, alu_y;

  assign opd_ld = {ctl.ld_x, ctl.ld_c, ctl.ld_b, ctl.ld_a};

  for (genvar i = 0; i < N_OPD; i++) begin : g_opd
    logic [W-1:0] d;
    if (i < N_SCRATCH) begin : g_scratch
      assign d = ctl.use_alu ? alu_y : in_data;
    end else begin : g_fixed
      assign d = in_data;
    end
    qe_reg #(.W(W)) u_reg (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (opd_ld[i]),
      .d    (d),
      .q    (opd_q[i])
    );
    assign opd_flat[i*W +: W] = opd_q[i];
  end

  qe_opmux #(.W(W), .N(N_OPD)) u_mux_p (
    .srcs(opd_flat), .sel(ctl.sel_p), .y(mux_p)
  );
  qe_opmux #(.W(W), .N(N_OPD)) u_mux_q (
    .srcs(opd_flat), .sel(ctl.sel_q), .y(mux_q)
  );

  qe_alu #(.W(W)) u_alu (
    .op(ctl.op), .p(mux_p), .q(mux_q), .y(alu_y)
  );

  qe_reg #(.W(W)) u_res (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (ctl.ld_r),
    .d    (alu_y),
    .q    (result)
  );
endmodule

// File: rtl/quad_eval.sv
module quad_eval import qe_pkg::*; #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic [W-1:0] result,
  output logic         done
);
  qe_ctl_t ctl;

  qe_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(in_valid),
    .in_ready(in_ready),
    .ctl     (ctl),
    .done    (done)
  );

  qe_dpath #(.W(W)) u_dpath (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctl    (ctl),
    .in_data(in_data),
    .result (result)
  );
endmodule

// File: rtl/qe_checker.sv
module qe_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] result,
  input logic         done
);
  logic [2:0] acc_cnt;
  logic [2:0] since_x;
  logic       done_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_cnt   <= '0;
      since_x   <= '0;
      done_seen <= 1'b0;
    end else begin
      if (in_valid && in_ready && acc_cnt != 3'd7) acc_cnt <= acc_cnt + 3'd1;
      if (in_valid && in_ready && acc_cnt == 3'd3) since_x <= '0;
      else if (since_x != 3'd7)                    since_x <= since_x + 3'd1;
      if (done) done_seen <= 1'b1;
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |-> (result == '0 && !done && in_ready)); // R1
  AST_FOUR_WORDS_MAX: assert property (@(posedge clk) disable iff (!rst_n) acc_cnt <= 3'd4); // R3
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n) acc_cnt == 3'd4 |-> !in_ready); // R3
  AST_DONE_TIMING: assert property (@(posedge clk) disable iff (!rst_n) done |-> (acc_cnt == 3'd4 && since_x == 3'd5)); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R5
  AST_DONE_ONCE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !done_seen); // R6
  AST_RESULT_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n) !$stable(result) |-> done); // R6
endmodule

bind quad_eval qe_checker #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_valid(in_valid),
  .in_ready(in_ready),
  .result  (result),
  .done    (done)
);

// File: tb/tb_quad_eval.sv
`timescale 1ns/1ps
module tb_quad_eval;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready;
  logic [7:0] result;
  logic       done;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  int cycles = 0;

  always #4 clk = ~clk;

  quad_eval dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .result(result), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  // reset held over two edges; R1 checked while asserted
  task automatic t_reset();
    in_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(result == 8'd0, "R1 result", result, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(in_ready == 1'b1, "R1 ready", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // load A,B,C,x with optional stalls, then check timing, value and hold
  task automatic t_eval(input int a, input int b, input int c, input int x, input int stall);
    int ops[4];
    int exp;
    ops[0] = a; ops[1] = b; ops[2] = c; ops[3] = x;
    exp = (c * x * x + b * x + a) & 255;
    for (int i = 0; i < 4; i++) begin
      for (int s = 0; s < stall; s++) begin
        in_valid = 1'b0;
        in_data  = 8'hA5;          // R8: garbage while stalled
        @(negedge clk);
        chk(in_ready == 1'b1, "R8 ready during stall", in_ready, 1);
      end
      in_valid = 1'b1;
      in_data  = ops[i][7:0];
      chk(in_ready == 1'b1, "R2 ready while loading", in_ready, 1);
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_data  = 8'h5A;
    chk(done == 1'b0, "R5 done early", done, 0);
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      chk(done == 1'b0, "R5 done early", done, 0);
    end
    @(negedge clk);
    chk(done == 1'b1, "R5 done on cycle 5", done, 1);
    chk(result == exp[7:0], "R4 R2 result value", result, exp);
    @(negedge clk);
    chk(done == 1'b0, "R5 done single cycle", done, 0);
    chk(result == exp[7:0], "R6 result held", result, exp);
    in_valid = 1'b1;
    in_data  = 8'h77;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(in_ready == 1'b0, "R3 ready low after load", in_ready, 0);
      chk(result == exp[7:0], "R6 result unchanged", result, exp);
      chk(done == 1'b0, "R6 no second done", done, 0);
    end
    in_valid = 1'b0;
  endtask

  // reset asserted between edges in the middle of a computation
  task automatic t_midreset();
    in_valid = 1'b1;
    for (int i = 0; i < 4; i++) begin
      in_data = 8'(i + 9);
      @(negedge clk);
    end
    in_valid = 1'b0;
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1;
    chk(result == 8'd0, "R7 result cleared", result, 0);
    chk(in_ready == 1'b1, "R7 ready restored", in_ready, 1);
    chk(done == 1'b0, "R7 done low", done, 0);
    @(negedge clk);
    rst_n = 1'b1;
    // partial load then reset: the next run must start again at A
    in_valid = 1'b1;
    in_data = 8'd200;
    @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_eval(3, 5, 2, 4, 0);          // R7: 32+20+3 = 55
  endtask

  task automatic t_random(input int n);
    int a, b, c, x;
    for (int r = 0; r < n; r++) begin
      do begin
        x = $urandom_range(0, 7);
        b = $urandom_range(0, 31);
        c = $urandom_range(0, 15);
        a = $urandom_range(0, 255);
      end while (b * x > 255 || c * x > 255 || c * x * x > 255 ||
                 a + b * x > 255 || c * x * x + b * x + a > 255);
      t_reset();
      t_eval(a, b, c, x, r % 3);
    end
  endtask

  initial begin
    void'($urandom(32'd17));
    t_reset();
    t_eval(1, 2, 3, 4, 0);          // 48+8+1 = 57
    t_reset();
    t_eval(7, 0, 0, 9, 2);          // constant term only, with stalls
    t_reset();
    t_eval(0, 0, 0, 0, 1);          // all zero
    t_reset();
    t_eval(5, 3, 15, 4, 0);         // 240+12 > 255? no: 240+12+5 = 257 wraps
    t_reset();
    t_eval(4, 10, 14, 4, 3);        // 224+40+4 > 255 -> wraps modulo 256
    t_reset();
    t_eval(0, 255, 0, 1, 0);        // top of range: 255
    t_reset();
    t_midreset();
    t_random(10);
    finish_run();
  end
endmodule